// File: doc/BRIEF.md
# Pixel Hit Time and Charge Recorder

This block is the digital back end of one pixel. It watches the discriminator output and, for every hit, records when the hit arrived and how long the pulse stayed above threshold. A shared timestamp bus gives the coarse arrival time, which is latched on the rising edge of the discriminator. The 40 MHz coarse clock period is then split into sixteen parts by a fine counter. This counter runs only from the discriminator edge until the next coarse clock edge, so it measures the remainder of the coarse period. While the discriminator stays high, the coarse edges are counted to give the time-over-threshold.

The logic runs on the fast clock (nominally 640 MHz, sixteen cycles per coarse period). The coarse clock arrives as a single-cycle enable, `coarse_tick`, so the fine counter is the fast clock gated by its own run flag. A two-bit mode input selects how hits are handled:
- Arrival time plus time-over-threshold.
- Arrival time only.
- Event counting with integrated time-over-threshold. In this mode the shutter input gates the counting, and one word is produced when the shutter closes.

Every word carries the pixel's column and row. A finished word is held, and further discriminator edges are ignored, until the readout acknowledges it.

Top module: `hit_time_charge_rec`

## Requirements
- R1: After reset, `hit_valid` is 0 and `hit_word` is all zeros.
- R2: Mode encoding is 00 = arrival time plus time-over-threshold, 01 = arrival time only, 10 = event count, 11 = same as 00. In the arrival-time modes the word is {col[43:36], row[35:28], coarse time[27:14], fine time[13:10], time-over-threshold[9:0]}.
- R3: The coarse time field equals the `ts_bus` value present in the clock cycle where the discriminator is first seen high.
- R4: The fine time field counts the fast cycles from the edge cycle (inclusive) up to the next cycle with `coarse_tick` (exclusive). It is 0 when the edge and the tick fall in the same cycle, and it saturates at 15.
- R5: The time-over-threshold field counts the cycles in which `disc` and `coarse_tick` are both high, from the edge cycle to the end of the pulse. It saturates at 1023.
- R6: In mode 01 the time-over-threshold field [9:0] is zero.
- R7: In the arrival-time modes, `hit_valid` rises once `disc` is low and the fine count has stopped. It then stays high until a cycle with `ack` high, and falls after that cycle.
- R8: While `hit_valid` is high, discriminator edges are ignored and `hit_word` does not change.
- R9: In mode 10 a rising `shutter` clears both counters. While `shutter` is high, each discriminator rising edge adds 1 to the event count, and each cycle with `disc` and `coarse_tick` both high adds 1 to the integrated time (which saturates at 16383). When `shutter` falls, the word {col, row, integrated time[27:14], event count[13:4], 4'b0000} becomes valid.
- R10: The event count saturates at 1023.
- R11: Driving `rst_n` low clears `hit_valid` and `hit_word` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock (sixteen cycles per coarse period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode, encoded as in R2 |
| disc | input | 1 | Discriminator output, synchronous to clk_fast |
| coarse_tick | input | 1 | One-cycle pulse marking each coarse clock rising edge |
| ts_bus | input | 14 | Shared coarse timestamp |
| shutter | input | 1 | Counting window for event-count mode |
| pix_col | input | 8 | Pixel column coordinate |
| pix_row | input | 8 | Pixel row coordinate |
| ack | input | 1 | Readout acknowledge of the held word |
| hit_valid | output | 1 | Hit word is held and ready |
| hit_word | output | 44 | Assembled hit word |

## Verification
The discriminator edge can land in the same fast cycle as a coarse tick. In that cycle the fine counter must stop at zero while the time-over-threshold counter starts at one. The bench places the edge on every phase of interest: 0, 1 and a middle phase. For each placement it compares both fields with counts that it keeps itself, by watching `coarse_tick` during the pulse. A second coincidence is a rising shutter together with a discriminator edge in event-count mode. There, the clear and the first increment must combine into a count of one.

// File: rtl/hitrec_pkg.sv
package hitrec_pkg;
  localparam int COORD_W = 8;
  localparam int TS_W    = 14;
  localparam int FINE_W  = 4;
  localparam int TOT_W   = 10;

  typedef enum logic [1:0] {
    MODE_TOA_TOT = 2'b00,
    MODE_TOA     = 2'b01,
    MODE_EVENT   = 2'b10,
    MODE_ALT     = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_FULL = 2'b10
  } state_e;
endpackage

// File: rtl/hitrec_rst_sync.sv
module hitrec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_sn <= meta_q;
    end
  end
endmodule

// File: rtl/hitrec_sat_ctr.sv
module hitrec_sat_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (clr)
      q_n = {{(W-1){1'b0}}, inc};
    else if (inc && (q != MAX))
      q_n = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  // R5 R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q == MAX && !clr) |=> (q == MAX));
endmodule

// File: rtl/hitrec_fine_timer.sv
module hitrec_fine_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         tick,
  output logic         run,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic         run_n;
  logic [W-1:0] count_n;

  always_comb begin
    run_n   = run;
    count_n = count;
    if (start) begin
      if (tick) begin
        run_n   = 1'b0;
        count_n = '0;
      end else begin
        run_n   = 1'b1;
        count_n = {{(W-1){1'b0}}, 1'b1};
      end
    end else if (run) begin
      if (tick)
        run_n = 1'b0;
      else if (count != MAX)
        count_n = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      count <= '0;
    end else begin
      run   <= run_n;
      count <= count_n;
    end
  end

  // R4
  fine_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !start) |=> (!run && $stable(count)));

  // R4
  fine_coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tick) |=> (!run && count == '0));
endmodule

// File: rtl/hit_time_charge_rec.sv
module hit_time_charge_rec
  import hitrec_pkg::*;
#(
  parameter int COORD_BITS = COORD_W,
  parameter int TS_BITS    = TS_W,
  parameter int FINE_BITS  = FINE_W,
  parameter int TOT_BITS   = TOT_W
) (
  input  logic                                            clk_fast,
  input  logic                                            rst_n,
  input  logic [1:0]                                      mode,
  input  logic                                            disc,
  input  logic                                            coarse_tick,
  input  logic [TS_BITS-1:0]                              ts_bus,
  input  logic                                            shutter,
  input  logic [COORD_BITS-1:0]                           pix_col,
  input  logic [COORD_BITS-1:0]                           pix_row,
  input  logic                                            ack,
  output logic                                            hit_valid,
  output logic [2*COORD_BITS+TS_BITS+FINE_BITS+TOT_BITS-1:0] hit_word
);
  localparam int WORD_BITS = 2*COORD_BITS + TS_BITS + FINE_BITS + TOT_BITS;
  localparam int ITOT_BITS = TS_BITS;
  localparam int CNT_BITS  = TOT_BITS;

  logic rst_sn;

  hitrec_rst_sync u_rst (
    .clk    (clk_fast),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  state_e                state_q, state_n;
  logic                  disc_q, shutter_q;
  logic [TS_BITS-1:0]    toa_q, toa_n;
  logic [WORD_BITS-1:0]  word_q, word_n;

  logic rise, shut_rise, shut_fall, ev_mode, toa_only;
  logic fine_start, fine_run;
  logic [FINE_BITS-1:0] fine_cnt;
  logic tot_clr, tot_inc, evc_clr, evc_inc, itot_clr, itot_inc;
  logic [TOT_BITS-1:0]  tot_cnt;
  logic [CNT_BITS-1:0]  evc_cnt;
  logic [ITOT_BITS-1:0] itot_cnt;

  assign rise      = disc & ~disc_q;
  assign shut_rise = shutter & ~shutter_q;
  assign shut_fall = ~shutter & shutter_q;
  assign ev_mode   = (mode == MODE_EVENT);
  assign toa_only  = (mode == MODE_TOA);

  hitrec_fine_timer #(.W(FINE_BITS)) u_fine (
    .clk   (clk_fast),
    .rst_n (rst_sn),
    .start (fine_start),
    .tick  (coarse_tick),
    .run   (fine_run),
    .count (fine_cnt)
  );

  hitrec_sat_ctr #(.W(TOT_BITS)) u_tot (
    .clk (clk_fast), .rst_n (rst_sn), .clr (tot_clr), .inc (tot_inc), .q (tot_cnt)
  );

  hitrec_sat_ctr #(.W(CNT_BITS)) u_evc (
    .clk (clk_fast), .rst_n (rst_sn), .clr (evc_clr), .inc (evc_inc), .q (evc_cnt)
  );

  hitrec_sat_ctr #(.W(ITOT_BITS)) u_itot (
    .clk (clk_fast), .rst_n (rst_sn), .clr (itot_clr), .inc (itot_inc), .q (itot_cnt)
  );

  always_comb begin
    state_n    = state_q;
    toa_n      = toa_q;
    word_n     = word_q;
    fine_start = 1'b0;
    tot_clr    = 1'b0;
    tot_inc    = 1'b0;
    evc_clr    = 1'b0;
    evc_inc    = 1'b0;
    itot_clr   = 1'b0;
    itot_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ev_mode) begin
          evc_clr  = shut_rise;
          itot_clr = shut_rise;
          evc_inc  = shutter & rise;
          itot_inc = shutter & disc & coarse_tick;
          if (shut_fall) begin
            state_n = ST_FULL;
            word_n  = {pix_col, pix_row, itot_cnt, evc_cnt, {FINE_BITS{1'b0}}};
          end
        end else if (rise) begin
          state_n    = ST_BUSY;
          toa_n      = ts_bus;
          fine_start = 1'b1;
          tot_clr    = 1'b1;
          tot_inc    = coarse_tick;
        end
      end
      ST_BUSY: begin
        tot_inc = disc & coarse_tick;
        if (!disc && !fine_run) begin
          state_n = ST_FULL;
          word_n  = {pix_col, pix_row, toa_q, fine_cnt,
                     toa_only ? {TOT_BITS{1'b0}} : tot_cnt};
        end
      end
      ST_FULL: begin
        if (ack) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_fast or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q   <= ST_IDLE;
      disc_q    <= 1'b0;
      shutter_q <= 1'b0;
      toa_q     <= '0;
      word_q    <= '0;
    end else begin
      state_q   <= state_n;
      disc_q    <= disc;
      shutter_q <= shutter;
      toa_q     <= toa_n;
      word_q    <= word_n;
    end
  end

  assign hit_valid = (state_q == ST_FULL);
  assign hit_word  = word_q;

  // R7
  valid_hold_chk: assert property (@(posedge clk_fast) disable iff (!rst_sn)
    (hit_valid && !ack) |=> hit_valid);

  // R7
  valid_drop_chk: assert property (@(posedge clk_fast) disable iff (!rst_sn)
    (hit_valid && ack) |=> !hit_valid);

  // R8
  word_stable_chk: assert property (@(posedge clk_fast) disable iff (!rst_sn)
    (hit_valid && !ack) |=> $stable(hit_word));

  // R6
  toa_only_tot_zero_chk: assert property (@(posedge clk_fast) disable iff (!rst_sn)
    ($rose(hit_valid) && mode == MODE_TOA) |-> (hit_word[TOT_BITS-1:0] == '0));
endmodule

// File: tb/tb_hit_time_charge_rec.sv
`timescale 1ns/1ps
module tb_hit_time_charge_rec;
  logic        clk_fast = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        disc, coarse_tick, shutter, ack;
  logic [13:0] ts_bus;
  logic [7:0]  pix_col, pix_row;
  logic        hit_valid;
  logic [43:0] hit_word;

  int checks = 0;
  int fails  = 0;
  int phase  = 0;
  logic [13:0] ts = 14'd100;

  always #2.5 clk_fast = ~clk_fast;

  hit_time_charge_rec dut (
    .clk_fast (clk_fast), .rst_n (rst_n), .mode (mode), .disc (disc),
    .coarse_tick (coarse_tick), .ts_bus (ts_bus), .shutter (shutter),
    .pix_col (pix_col), .pix_row (pix_row), .ack (ack),
    .hit_valid (hit_valid), .hit_word (hit_word)
  );

  task automatic check(input string req, input logic [43:0] got, input logic [43:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // one clock; inputs set afterwards apply at the next edge
  task automatic cyc();
    @(posedge clk_fast);
    #1;
    phase = (phase + 1) % 16;
    if (phase == 0) ts = ts + 14'd1;
    coarse_tick = (phase == 0);
    ts_bus = ts;
  endtask

  task automatic wait_phase(input int p);
    while (phase != p) cyc();
  endtask

  task automatic pulse(input int d, input int len, output int tot, output logic [13:0] toa);
    wait_phase(d);
    toa = ts_bus;
    disc = 1'b1;
    tot = 0;
    for (int i = 0; i < len; i++) begin
      if (coarse_tick) tot++;
      cyc();
    end
    disc = 1'b0;
    cyc();
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 100 && !hit_valid; i++) cyc();
  endtask

  task automatic do_ack(input string req);
    ack = 1'b1;
    cyc();
    ack = 1'b0;
    cyc();
    check(req, {43'd0, hit_valid}, 44'd0);
  endtask

  task automatic hit_case(input string req, input logic [1:0] m, input int d, input int len);
    int tot;
    logic [13:0] toa;
    logic [3:0] fine;
    mode = m;
    pulse(d, len, tot, toa);
    wait_valid();
    fine = (d == 0) ? 4'd0 : 4'(16 - d);
    if (tot > 1023) tot = 1023;
    if (m == 2'b01) tot = 0;
    check({req, " valid"}, {43'd0, hit_valid}, 44'd1);
    check({req, " word"}, hit_word, {pix_col, pix_row, toa, fine, 10'(tot)});
    do_ack("R7 ack clears valid");
  endtask

  task automatic test_reset();
    check("R1 valid after reset", {43'd0, hit_valid}, 44'd0);
    check("R1 word after reset", hit_word, 44'd0);
  endtask

  task automatic test_ignore();
    int tot, tot2;
    logic [13:0] toa, toa2;
    logic [43:0] held;
    mode = 2'b00;
    pulse(7, 20, tot, toa);
    wait_valid();
    held = hit_word;
    check("R8 first hit", held, {pix_col, pix_row, toa, 4'd9, 10'(tot)});
    pulse(3, 40, tot2, toa2);
    check("R8 valid kept while ignored", {43'd0, hit_valid}, 44'd1);
    check("R8 word unchanged by ignored edge", hit_word, held);
    do_ack("R8 ack after ignore");
  endtask

  task automatic test_event(input int npulse, input string req);
    int itot = 0;
    int cnt = 0;
    mode = 2'b10;
    cyc();
    wait_phase(5);
    shutter = 1'b1;
    disc = 1'b1;
    if (coarse_tick) itot++;
    cnt++;
    cyc();
    disc = 1'b0;
    cyc();
    for (int p = 1; p < npulse; p++) begin
      disc = 1'b1;
      for (int k = 0; k < 2 + (p % 3); k++) begin
        if (coarse_tick) itot++;
        cyc();
      end
      disc = 1'b0;
      cyc();
      cnt++;
    end
    shutter = 1'b0;
    cyc();
    wait_valid();
    if (cnt > 1023) cnt = 1023;
    check({req, " event valid"}, {43'd0, hit_valid}, 44'd1);
    check({req, " event word"}, hit_word, {pix_col, pix_row, 14'(itot), 10'(cnt), 4'd0});
    do_ack("R9 event ack");
  endtask

  task automatic test_async_reset();
    int tot;
    logic [13:0] toa;
    mode = 2'b00;
    pulse(4, 10, tot, toa);
    wait_valid();
    check("R11 hit before reset", {43'd0, hit_valid}, 44'd1);
    #1 rst_n = 1'b0;
    #0.5;
    check("R11 valid cleared without clock", {43'd0, hit_valid}, 44'd0);
    check("R11 word cleared without clock", hit_word, 44'd0);
    cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    check("R1 valid after second reset", {43'd0, hit_valid}, 44'd0);
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'b00; disc = 1'b0; coarse_tick = 1'b0; shutter = 1'b0;
    ack = 1'b0; ts_bus = ts; pix_col = 8'h5A; pix_row = 8'hC3;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    test_reset();
    hit_case("R2 R3 R4 R5 mid phase", 2'b00, 5, 40);
    hit_case("R4 R5 edge on tick", 2'b00, 0, 20);
    hit_case("R4 edge one after tick", 2'b00, 1, 3);
    pix_col = 8'h01; pix_row = 8'hFE;
    hit_case("R2 R3 alt mode 11", 2'b11, 9, 50);
    hit_case("R6 arrival only", 2'b01, 6, 37);
    test_ignore();
    hit_case("R5 tot saturation", 2'b00, 3, 1030 * 16);
    test_event(6, "R9");
    test_event(1030, "R10 count saturation");
    test_async_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule